// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block keeps track of the atomic reservation of a single hardware thread that sits beside its L1 data cache. It accepts three kinds of atomic request: load-linked, store-conditional and compare-and-swap. Load-linked and compare-and-swap always fetch the line with intent to modify, and they record whether the coherence fabric granted exclusive ownership. For store-conditional and compare-and-swap the block reports a 2-bit result. While a reservation is open it holds a strict-ordering flag high, so that the pipeline falls back to sequential ordering for the length of the atomic sequence.

A reservation covers a whole line of `LINE_BYTES` bytes. When another agent snoops the reserved line, thread priorities decide the outcome. A snooper with strictly higher priority takes the line and the local reservation is broken. On equal or lower priority the local holder keeps the line, and the snoop response denies exclusive ownership to the snooper. A load-linked that is not granted exclusive ownership still completes normally, and the failure shows up at the following store-conditional. A compare-and-swap that is not granted exclusive ownership fails weakly at once and does not compare any data.

Result codes are 00 for success, 01 for weak failure (exclusivity lost), 10 for strong failure (compare mismatch) and 11 for no reservation. Request opcodes are 00 for load-linked, 01 for store-conditional, 10 for compare-and-swap and 11 for no operation.

Top module: `atomic_resv_monitor`

## Requirements
- R1: Each load-linked and each compare-and-swap raises `fetchValid` with `fetchExcl`=1 and a line-aligned `fetchAddr` (low log2(LINE_BYTES) bits zero). The request is held until `fetchReady`. A store-conditional never fetches.
- R2: A load-linked answers with code 00 and the fetched data in the grant cycle, whether or not exclusive was granted. If exclusive was not granted, the reservation is broken and the next store-conditional to that line answers 01 without a store.
- R3: A compare-and-swap granted without exclusive ownership answers 01 in the grant cycle, whatever the data, and does not store.
- R4: A compare-and-swap granted with exclusive ownership answers 00 and pulses `storeValid` with the new data when the fetched data equals the compare value. Otherwise it answers 10 and does not store.
- R5: A store-conditional with no reservation, or to a line other than the reserved one, answers 11 and does not store.
- R6: A store-conditional to any byte of the reserved, unbroken line answers 00 one cycle after acceptance, with `storeValid`, the request address and its write data.
- R7: A snoop that hits an unbroken reservation with priority strictly greater than `myPrio` is answered one cycle later with exclusive granted, and it breaks the reservation.
- R8: A snoop that hits an unbroken reservation with priority equal to or lower than `myPrio` is answered with exclusive denied, and the reservation survives.
- R9: A snoop to another line, with no reservation, or on a broken reservation is answered with exclusive granted.
- R10: `orderStrict` is high from the cycle after a load-linked answers through the cycle in which a store-conditional or compare-and-swap answers, and low after that.
- R11: Every store-conditional or compare-and-swap answer, whether success or failure, clears the reservation.
- R12: A no-operation request answers 11 one cycle after acceptance and leaves the reservation unchanged.
- R13: `reqReady` is high only when no request is in flight, and one request is handled at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| myPrio | input | PRIO_W | Priority of the local thread |
| reqValid | input | 1 | Atomic request valid |
| reqReady | output | 1 | Request accepted when high |
| reqOp | input | 2 | Opcode: 00 LL, 01 SC, 10 CAS, 11 no-op |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqCmpData | input | DATA_W | CAS compare value |
| reqWrData | input | DATA_W | SC or CAS write data |
| rspValid | output | 1 | Result valid (one cycle) |
| rspCode | output | 2 | 00 ok, 01 weak, 10 strong, 11 no reservation |
| rspData | output | DATA_W | Fetched data for LL and CAS, else zero |
| fetchValid | output | 1 | Fetch request to coherence port |
| fetchReady | input | 1 | Fetch request taken |
| fetchAddr | output | ADDR_W | Line-aligned fetch address |
| fetchExcl | output | 1 | Fetch asks for exclusive ownership |
| grantValid | input | 1 | Fetch response valid |
| grantExcl | input | 1 | Exclusive ownership granted |
| grantData | input | DATA_W | Data returned with the grant |
| storeValid | output | 1 | Perform the conditional store |
| storeAddr | output | ADDR_W | Store byte address |
| storeData | output | DATA_W | Store data |
| snpValid | input | 1 | Incoming snoop valid |
| snpReady | output | 1 | Snoop accepted (always high) |
| snpAddr | input | ADDR_W | Snooped byte address |
| snpPrio | input | PRIO_W | Priority of the snooping thread |
| snpRspValid | output | 1 | Snoop response valid, one cycle after the snoop |
| snpRspExcl | output | 1 | Snooper may take exclusive ownership |
| orderStrict | output | 1 | Strict sequential ordering while reserved |

## Verification
The bench builds the block with `PRIO_W`=2, `DATA_W`=16 and the default 64-byte line. With a 2-bit priority, snoops that are lower than, equal to and higher than the local priority all come from a handful of values. The narrow data width makes equal and unequal compare-and-swap values easy to pick. Byte offsets inside and just outside the 64-byte line test that the compare ignores the low six address bits.

// File: rtl/resv_monitor_pkg.sv
package resv_monitor_pkg;

  typedef enum logic [1:0] {
    OP_LL   = 2'b00,
    OP_SC   = 2'b01,
    OP_CAS  = 2'b10,
    OP_NONE = 2'b11
  } atomOp_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'b00,
    RES_WEAK   = 2'b01,
    RES_STRONG = 2'b10,
    RES_NORESV = 2'b11
  } atomRes_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic setResv;
    logic clearResv;
    logic rspDataSel;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic resvValid;
    logic resvBroken;
    logic capLineHit;
    logic casEqual;
  } dpStat_t;

endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_monitor_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int PRIO_W     = 3,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat,
  input  logic [PRIO_W-1:0] myPrio,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqCmpData,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              grantExcl,
  input  logic [DATA_W-1:0] grantData,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [PRIO_W-1:0] snpPrio,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] rspData,
  output logic              snpRspValid,
  output logic              snpRspExcl,
  output logic              orderStrict
);

  localparam int OFFS_W = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capCmp;
  logic [DATA_W-1:0] capWr;
  logic [LINE_W-1:0] resvLine;
  logic              resvValid;
  logic              resvBroken;
  logic              snpRspValidQ;
  logic              snpRspExclQ;

  logic [LINE_W-1:0] capLine;
  logic [LINE_W-1:0] snpLine;
  logic              snpHit;
  logic              snpWins;

  assign capLine = capAddr[ADDR_W-1:OFFS_W];
  assign snpLine = snpAddr[ADDR_W-1:OFFS_W];
  assign snpHit  = snpValid && resvValid && !resvBroken && (snpLine == resvLine);
  assign snpWins = snpPrio > myPrio;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capCmp  <= '0;
      capWr   <= '0;
    end else if (ctrl.captureReq) begin
      capAddr <= reqAddr;
      capCmp  <= reqCmpData;
      capWr   <= reqWrData;
    end
  end

  // reservation state: clear beats set beats snoop break
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resvValid  <= 1'b0;
      resvBroken <= 1'b0;
      resvLine   <= '0;
    end else if (ctrl.clearResv) begin
      resvValid  <= 1'b0;
      resvBroken <= 1'b0;
    end else if (ctrl.setResv) begin
      resvValid  <= 1'b1;
      resvBroken <= !grantExcl;
      resvLine   <= capLine;
    end else if (snpHit && snpWins) begin
      resvBroken <= 1'b1;
    end
  end

  // snoop response, one cycle after the snoop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snpRspValidQ <= 1'b0;
      snpRspExclQ  <= 1'b0;
    end else begin
      snpRspValidQ <= snpValid;
      snpRspExclQ  <= snpValid && (!snpHit || snpWins);
    end
  end

  assign stat.resvValid  = resvValid;
  assign stat.resvBroken = resvBroken;
  assign stat.capLineHit = resvLine == capLine;
  assign stat.casEqual   = grantData == capCmp;

  assign fetchAddr   = {capLine, {OFFS_W{1'b0}}};
  assign storeAddr   = capAddr;
  assign storeData   = capWr;
  assign rspData     = ctrl.rspDataSel ? grantData : '0;
  assign snpRspValid = snpRspValidQ;
  assign snpRspExcl  = snpRspExclQ;
  assign orderStrict = resvValid;

endmodule

// File: rtl/resv_control.sv
module resv_control
  import resv_monitor_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  output logic       reqReady,
  output logic       fetchValid,
  input  logic       fetchReady,
  input  logic       grantValid,
  input  logic       grantExcl,
  input  dpStat_t    stat,
  output dpCtrl_t    ctrl,
  output logic       rspValid,
  output logic [1:0] rspCode,
  output logic       storeValid
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_SCEVAL,
    ST_NOOP
  } ctlState_e;

  ctlState_e state, stateNext;
  atomOp_e   opQ;
  atomRes_e  code;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_NONE;
    end else begin
      state <= stateNext;
      if (ctrl.captureReq) opQ <= atomOp_e'(reqOp);
    end
  end

  always_comb begin
    stateNext  = state;
    ctrl       = '0;
    reqReady   = 1'b0;
    fetchValid = 1'b0;
    rspValid   = 1'b0;
    storeValid = 1'b0;
    code       = RES_OK;
    unique case (state)
      ST_IDLE: begin
        reqReady        = 1'b1;
        ctrl.captureReq = reqValid;
        if (reqValid) begin
          unique case (atomOp_e'(reqOp))
            OP_LL, OP_CAS: stateNext = ST_FETCH;
            OP_SC:         stateNext = ST_SCEVAL;
            default:       stateNext = ST_NOOP;
          endcase
        end
      end
      ST_FETCH: begin
        fetchValid = 1'b1;
        if (fetchReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (grantValid) begin
          rspValid        = 1'b1;
          ctrl.rspDataSel = 1'b1;
          stateNext       = ST_IDLE;
          if (opQ == OP_LL) begin
            ctrl.setResv = 1'b1;
            code         = RES_OK;
          end else begin
            ctrl.clearResv = 1'b1;
            if (!grantExcl)         code = RES_WEAK;
            else if (stat.casEqual) code = RES_OK;
            else                    code = RES_STRONG;
            storeValid = grantExcl && stat.casEqual;
          end
        end
      end
      ST_SCEVAL: begin
        rspValid       = 1'b1;
        ctrl.clearResv = 1'b1;
        stateNext      = ST_IDLE;
        if (!stat.resvValid || !stat.capLineHit) code = RES_NORESV;
        else if (stat.resvBroken)               code = RES_WEAK;
        else begin
          code       = RES_OK;
          storeValid = 1'b1;
        end
      end
      default: begin
        rspValid  = 1'b1;
        code      = RES_NORESV;
        stateNext = ST_IDLE;
      end
    endcase
  end

  assign rspCode = code;

endmodule

// File: rtl/atomic_resv_monitor.sv
module atomic_resv_monitor
  import resv_monitor_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int PRIO_W     = 3,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRIO_W-1:0] myPrio,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqCmpData,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              rspValid,
  output logic [1:0]        rspCode,
  output logic [DATA_W-1:0] rspData,
  output logic              fetchValid,
  input  logic              fetchReady,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchExcl,
  input  logic              grantValid,
  input  logic              grantExcl,
  input  logic [DATA_W-1:0] grantData,
  output logic              storeValid,
  output logic [ADDR_W-1:0] storeAddr,
  output logic [DATA_W-1:0] storeData,
  input  logic              snpValid,
  output logic              snpReady,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [PRIO_W-1:0] snpPrio,
  output logic              snpRspValid,
  output logic              snpRspExcl,
  output logic              orderStrict
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  resv_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .reqReady   (reqReady),
    .fetchValid (fetchValid),
    .fetchReady (fetchReady),
    .grantValid (grantValid),
    .grantExcl  (grantExcl),
    .stat       (stat),
    .ctrl       (ctrl),
    .rspValid   (rspValid),
    .rspCode    (rspCode),
    .storeValid (storeValid)
  );

  resv_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PRIO_W     (PRIO_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .stat        (stat),
    .myPrio      (myPrio),
    .reqAddr     (reqAddr),
    .reqCmpData  (reqCmpData),
    .reqWrData   (reqWrData),
    .grantExcl   (grantExcl),
    .grantData   (grantData),
    .snpValid    (snpValid),
    .snpAddr     (snpAddr),
    .snpPrio     (snpPrio),
    .fetchAddr   (fetchAddr),
    .storeAddr   (storeAddr),
    .storeData   (storeData),
    .rspData     (rspData),
    .snpRspValid (snpRspValid),
    .snpRspExcl  (snpRspExcl),
    .orderStrict (orderStrict)
  );

  assign fetchExcl = 1'b1;
  assign snpReady  = 1'b1;

endmodule

// File: rtl/atomic_resv_checker.sv
module atomic_resv_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              fetchValid,
  input logic              fetchExcl,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              rspValid,
  input logic [1:0]        rspCode,
  input logic              storeValid,
  input logic              snpValid,
  input logic              snpRspValid,
  input logic              orderStrict
);

  localparam int OFFS_W = $clog2(LINE_BYTES);

  assert_fetch_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (fetchExcl && fetchAddr[OFFS_W-1:0] == '0));

  assert_weak_no_store_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode != 2'b00) |-> !storeValid);

  assert_store_needs_ok_R6: assert property (@(posedge clk) disable iff (!rstN)
    storeValid |-> (rspValid && rspCode == 2'b00));

  assert_snoop_answer_R9: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |=> snpRspValid);

  assert_order_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    storeValid |=> !orderStrict);

  assert_single_inflight_R13: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind atomic_resv_monitor atomic_resv_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .fetchValid  (fetchValid),
  .fetchExcl   (fetchExcl),
  .fetchAddr   (fetchAddr),
  .rspValid    (rspValid),
  .rspCode     (rspCode),
  .storeValid  (storeValid),
  .snpValid    (snpValid),
  .snpRspValid (snpRspValid),
  .orderStrict (orderStrict)
);

// File: tb/atomic_resv_monitor_test.sv
module atomic_resv_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 16;
  localparam int PRIO_W     = 2;
  localparam int LINE_BYTES = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PRIO_W-1:0] myPrio = '0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [1:0]        reqOp = 2'b11;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqCmpData = '0;
  logic [DATA_W-1:0] reqWrData = '0;
  logic              rspValid;
  logic [1:0]        rspCode;
  logic [DATA_W-1:0] rspData;
  logic              fetchValid;
  logic              fetchReady = 1'b0;
  logic [ADDR_W-1:0] fetchAddr;
  logic              fetchExcl;
  logic              grantValid = 1'b0;
  logic              grantExcl = 1'b0;
  logic [DATA_W-1:0] grantData = '0;
  logic              storeValid;
  logic [ADDR_W-1:0] storeAddr;
  logic [DATA_W-1:0] storeData;
  logic              snpValid = 1'b0;
  logic              snpReady;
  logic [ADDR_W-1:0] snpAddr = '0;
  logic [PRIO_W-1:0] snpPrio = '0;
  logic              snpRspValid;
  logic              snpRspExcl;
  logic              orderStrict;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_resv_monitor #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W), .LINE_BYTES(LINE_BYTES)
  ) uut (
    .clk(clk), .rstN(rstN), .myPrio(myPrio),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqCmpData(reqCmpData), .reqWrData(reqWrData),
    .rspValid(rspValid), .rspCode(rspCode), .rspData(rspData),
    .fetchValid(fetchValid), .fetchReady(fetchReady), .fetchAddr(fetchAddr), .fetchExcl(fetchExcl),
    .grantValid(grantValid), .grantExcl(grantExcl), .grantData(grantData),
    .storeValid(storeValid), .storeAddr(storeAddr), .storeData(storeData),
    .snpValid(snpValid), .snpReady(snpReady), .snpAddr(snpAddr), .snpPrio(snpPrio),
    .snpRspValid(snpRspValid), .snpRspExcl(snpRspExcl), .orderStrict(orderStrict)
  );

  // behavioural reference: phase 0 idle, 1 fetching, 2 awaiting grant, 3 SC verdict, 4 no-op
  int          mPhase = 0;
  int          mOp = 3;
  longint      mAddr = 0, mCmp = 0, mWr = 0;
  bit          mHeld = 0, mBroken = 0;
  longint      mLine = 0;
  bit          mSnpPend = 0, mSnpGrant = 0;

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // check outputs against the model for the current inputs, then advance one clock
  task automatic tick();
    bit     eRsp, eStore, eSnpHit, eSnpWin;
    int     eCode;
    string  rTag, sTag;
    longint eData;
    #1;
    eRsp = 0; eStore = 0; eCode = 0; eData = 0; rTag = "R13";
    if (mPhase == 2 && grantValid) begin
      eRsp = 1; eData = grantData;
      if (mOp == 0) begin eCode = 0; rTag = "R2"; end
      else if (!grantExcl) begin eCode = 1; rTag = "R3"; end
      else if (longint'(grantData) == mCmp) begin eCode = 0; eStore = 1; rTag = "R4"; end
      else begin eCode = 2; rTag = "R4"; end
    end else if (mPhase == 3) begin
      eRsp = 1;
      if (!mHeld || (mAddr / LINE_BYTES) != mLine) begin eCode = 3; rTag = "R5_R11"; end
      else if (mBroken) begin eCode = 1; rTag = "R2_R7"; end
      else begin eCode = 0; eStore = 1; rTag = "R6"; end
    end else if (mPhase == 4) begin
      eRsp = 1; eCode = 3; rTag = "R12";
    end
    check("R13", "reqReady", reqReady, mPhase == 0);
    check("R1", "fetchValid", fetchValid, mPhase == 1);
    if (mPhase == 1) begin
      check("R1", "fetchExcl", fetchExcl, 1);
      check("R1", "fetchAddr", fetchAddr, mAddr - (mAddr % LINE_BYTES));
    end
    check(rTag, "rspValid", rspValid, eRsp);
    if (eRsp) begin
      check(rTag, "rspCode", rspCode, eCode);
      check(rTag, "rspData", rspData, eData);
    end
    check(rTag, "storeValid", storeValid, eStore);
    if (eStore) begin
      check(rTag, "storeAddr", storeAddr, mAddr);
      check(rTag, "storeData", storeData, mWr);
    end
    check("R10", "orderStrict", orderStrict, mHeld);
    check("R9", "snpReady", snpReady, 1);
    check("R9", "snpRspValid", snpRspValid, mSnpPend);
    if (mSnpPend) check(mSnpGrant ? "R7_R9" : "R8", "snpRspExcl", snpRspExcl, mSnpGrant);

    // snoop decision on the current reservation
    eSnpHit = snpValid && mHeld && !mBroken && ((longint'(snpAddr) / LINE_BYTES) == mLine);
    eSnpWin = snpPrio > myPrio;
    mSnpPend  = snpValid;
    mSnpGrant = snpValid && (!eSnpHit || eSnpWin);
    sTag = "";
    // reservation update: answers clear, LL grant sets, winning snoop breaks
    if ((mPhase == 2 && grantValid && mOp != 0) || mPhase == 3) begin
      mHeld = 0; mBroken = 0;
    end else if (mPhase == 2 && grantValid) begin
      mHeld = 1; mBroken = !grantExcl; mLine = mAddr / LINE_BYTES;
    end else if (eSnpHit && eSnpWin) begin
      mBroken = 1;
    end
    // request progress
    case (mPhase)
      0: if (reqValid) begin
           mOp = reqOp; mAddr = reqAddr; mCmp = reqCmpData; mWr = reqWrData;
           mPhase = (reqOp == 0 || reqOp == 2) ? 1 : (reqOp == 1 ? 3 : 4);
         end
      1: if (fetchReady) mPhase = 2;
      2: if (grantValid) mPhase = 0;
      default: mPhase = 0;
    endcase
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(int op, longint addr, longint cmp, longint wr);
    reqValid = 1; reqOp = 2'(op); reqAddr = ADDR_W'(addr);
    reqCmpData = DATA_W'(cmp); reqWrData = DATA_W'(wr);
    tick();
    reqValid = 0;
  endtask

  task automatic serve(bit excl, longint data);
    fetchReady = 1; tick(); fetchReady = 0;
    grantValid = 1; grantExcl = excl; grantData = DATA_W'(data);
    tick();
    grantValid = 0; grantExcl = 0;
  endtask

  task automatic loadLinked(longint addr, bit excl, longint data);
    issue(0, addr, 0, 0); serve(excl, data);
  endtask

  task automatic storeCond(longint addr, longint wr);
    issue(1, addr, 0, wr); tick();
  endtask

  task automatic casOp(longint addr, longint cmp, longint wr, bit excl, longint data);
    issue(2, addr, cmp, wr); serve(excl, data);
  endtask

  task automatic snoop(longint addr, int prio);
    snpValid = 1; snpAddr = ADDR_W'(addr); snpPrio = PRIO_W'(prio);
    tick();
    snpValid = 0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // reset state (R13, R10)
    check("R13", "reqReady in reset", reqReady, 1);
    check("R10", "orderStrict in reset", orderStrict, 0);
    rstN = 1;
    @(negedge clk);
    tick();
    myPrio = 2'd1;

    // R5: SC with nothing reserved
    storeCond(32'h0000_1000, 16'h1111);

    // R6, R10, R11: LL then SC at another byte of the same line, then SC again
    loadLinked(32'h0000_1008, 1, 16'hABCD);
    tick();
    storeCond(32'h0000_103F, 16'h5555);
    storeCond(32'h0000_1000, 16'h6666);

    // R2: LL without exclusive, SC reports weak failure
    loadLinked(32'h0000_2000, 0, 16'h0042);
    storeCond(32'h0000_2004, 16'h7777);

    // R5 and R11: SC to the neighbouring line fails and clears
    loadLinked(32'h0000_3000, 1, 16'h0001);
    storeCond(32'h0000_3040, 16'h8888);
    storeCond(32'h0000_3000, 16'h8888);

    // R8, R9, R7: snoop priority outcomes
    loadLinked(32'h0000_4000, 1, 16'h0003);
    snoop(32'h0000_4020, 1);
    snoop(32'h0000_403F, 0);
    snoop(32'h0000_8000, 3);
    snoop(32'h0000_4000, 2);
    snoop(32'h0000_4010, 0);
    storeCond(32'h0000_4000, 16'h9999);
    snoop(32'h0000_4000, 0);

    // R3, R4: compare-and-swap outcomes
    casOp(32'h0000_5000, 16'h00AA, 16'h00BB, 0, 16'h00AA);
    casOp(32'h0000_5010, 16'h00AA, 16'h00BB, 1, 16'h00AA);
    casOp(32'h0000_5020, 16'h00AA, 16'h00BB, 1, 16'h00AB);

    // R11: CAS ends an open reservation
    loadLinked(32'h0000_6000, 1, 16'h0010);
    casOp(32'h0000_6000, 16'h0010, 16'h0020, 1, 16'h0010);
    storeCond(32'h0000_6000, 16'h0030);

    // R12: no-op leaves the reservation alone
    loadLinked(32'h0000_7000, 1, 16'h0011);
    issue(3, 32'h0000_7000, 0, 0);
    tick();
    storeCond(32'h0000_7000, 16'h0012);

    // R1, R13: held request while a slow fetch is pending
    issue(0, 32'h0000_9004, 0, 0);
    reqValid = 1; reqOp = 2'b01; reqAddr = 32'h0000_9004; reqWrData = 16'h0F0F;
    tick(); tick(); tick();
    fetchReady = 1; tick(); fetchReady = 0;
    tick();
    reqValid = 0;
    grantValid = 1; grantExcl = 1; grantData = 16'h0C0C; tick(); grantValid = 0;
    tick();
    storeCond(32'h0000_9000, 16'h0D0D);

    // R7 while a new LL is granted in the same cycle: the new reservation stands
    loadLinked(32'h0000_A000, 1, 16'h0001);
    issue(0, 32'h0000_A000, 0, 0);
    fetchReady = 1; tick(); fetchReady = 0;
    snpValid = 1; snpAddr = 32'h0000_A000; snpPrio = 2'd3;
    grantValid = 1; grantExcl = 1; grantData = 16'h0002; tick();
    grantValid = 0; snpValid = 0;
    tick();
    storeCond(32'h0000_A000, 16'h0003);

    repeat (3) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule